// File: doc/BRIEF.md
# Transmit Buffer Request Scheduler

This block keeps track of transmit requests for a small set of message buffers in a CAN-FD style controller. Host software asks for a transmission by writing a write-1-to-set mask to the add port. It withdraws requests through a second write-1-to-set mask on the cancel port. Five status words can be read at any time: pending, latched add requests, cancel requests, cancel-finished and transmission-occurred. Each buffer's message identifier arrives on its own slice of a packed input.

When a pending bit is set, or a frame ends, a serial priority scan visits every buffer once. It chooses the pending buffer with the numerically lowest identifier and offers it to the transmit engine on a valid/index pair. The engine takes the offer with a start pulse. It then reports the frame outcome with one pulse: success, lost arbitration or error. The host can cancel a buffer whose frame has not yet started, and that takes effect at once. Cancelling a buffer whose frame is on the bus is held back until the frame ends. With automatic retransmission disabled, every failed frame is dropped instead of being retried.

Top module: `txq_sched`

## Requirements
- R1: Buffer i owns bit i (i < NBUF) of every status word. Bits NBUF to 31 always read 0, and mask bits at those positions are ignored. After reset every status output and `sel_vld_o` are 0.
- R2: An add write sets the pending bit of every masked buffer in one write. Add bits for a buffer that is already pending are ignored: pending stays as it was and no new scan starts, so `sel_vld_o` stays high.
- R3: Outside a scan, an accepted add appears in `pend_o` one cycle after the write edge, and `addreq_o` stays 0. During a scan the add is held in `addreq_o`. It moves into `pend_o` on the first edge after the scan ends.
- R4: A scan starts one cycle after it is triggered and lasts NBUF cycles, with `sel_vld_o` low throughout. With no frame active, `sel_vld_o` rises NBUF+1 cycles after the add write edge. `sel_idx_o` then names the pending buffer with the lowest identifier, and on equal identifiers the lower index wins.
- R5: A buffer that becomes pending while a scan runs is not a candidate in that scan, even when its identifier is lower.
- R6: A cancel of a buffer that is not on the bus takes effect one edge after the cancel write edge. The pending and add bits clear, cancel-finished is set, and an offer for that buffer is withdrawn. The cancel-request bit clears one edge later.
- R7: A cancel of the buffer on the bus leaves it pending until the frame ends. It then clears pending and sets cancel-finished for every outcome. A success also sets transmission-occurred.
- R8: A successful frame clears the buffer's pending bit and sets its transmission-occurred bit. Without a cancel request, cancel-finished is left unchanged.
- R9: With `darm_i` low and no cancel request, a frame that loses arbitration or fails with an error stays pending. A new scan then offers it again.
- R10: With `darm_i` high, a failed frame clears pending and sets cancel-finished. A successful frame behaves as in R8.
- R11: An accepted add clears that buffer's cancel-finished and transmission-occurred bits.
- R12: `eng_start_i` while `sel_vld_o` is high starts the offered buffer, and `sel_vld_o` is low from the next cycle. A frame-end pulse triggers a new scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| add_we | input | 1 | Add-request mask write strobe |
| add_wdata | input | 32 | Add-request mask, write-1-to-set |
| cnl_we | input | 1 | Cancel-request mask write strobe |
| cnl_wdata | input | 32 | Cancel-request mask, write-1-to-set |
| darm_i | input | 1 | Disable automatic retransmission |
| msg_id_i | input | NBUF*IDW | Message identifier of each buffer, buffer 0 in the low slice |
| pend_o | output | 32 | Pending status per buffer |
| addreq_o | output | 32 | Add requests held during a scan |
| cnlreq_o | output | 32 | Outstanding cancel requests |
| cnldone_o | output | 32 | Cancel-finished status |
| txok_o | output | 32 | Transmission-occurred status |
| sel_vld_o | output | 1 | A buffer is offered to the transmit engine |
| sel_idx_o | output | IW | Index of the offered buffer |
| eng_start_i | input | 1 | Engine starts the offered frame |
| eng_ok_i | input | 1 | Frame ended successfully |
| eng_arb_i | input | 1 | Frame lost arbitration |
| eng_err_i | input | 1 | Frame ended with an error |

## Verification
The bench builds the block with NBUF=3 and IDW=3, so each identifier has only eight values. That makes it possible to sweep all 512 identifier triples against all seven non-empty add masks. Equal identifiers occur often in that sweep, which exercises the lower-index tie rule, and every sweep step also checks the exact offer latency and the immediate cancel path. Short directed sequences then cover the interleavings a sweep cannot reach: an add landing mid-scan, an add cancelled before its scan ends, cancels deferred across each frame outcome, and the two retransmission modes.

// File: rtl/txq_pkg.sv
package txq_pkg;
    // Width of every host-visible status and mask word
    localparam int REG_W = 32;

    typedef enum logic {
        SCAN_IDLE,
        SCAN_RUN
    } scan_st_e;
endpackage

// File: rtl/txq_scan.sv
// Serial priority scan: one candidate visited per cycle, lowest identifier wins,
// earlier (lower) index kept on a tie.
module txq_scan
    import txq_pkg::*;
#(
    parameter int NBUF = 3,
    parameter int IDW  = 11,
    localparam int IW  = (NBUF > 1) ? $clog2(NBUF) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [NBUF-1:0]     cand_i,
    input  logic [NBUF-1:0]     live_i,
    input  logic [NBUF*IDW-1:0] ids_i,
    output logic                busy_o,
    output logic                fin_o,
    output logic                found_o,
    output logic [IW-1:0]       idx_o
);
    localparam logic [IW-1:0] LAST = IW'(NBUF - 1);

    typedef struct packed {
        scan_st_e        st;
        logic [IW-1:0]   cnt;
        logic [NBUF-1:0] cand;
        logic            bvld;
        logic [IW-1:0]   bidx;
        logic [IDW-1:0]  bid;
    } scan_t;

    scan_t s_d, s_q;
    logic [IDW-1:0] cur_id;
    logic           take;
    logic           last;

    always_comb begin
        s_d    = s_q;
        cur_id = ids_i[s_q.cnt*IDW +: IDW];
        last   = (s_q.cnt == LAST);
        take   = 1'b0;
        unique case (s_q.st)
            SCAN_IDLE: begin
                if (start_i) begin
                    s_d.st   = SCAN_RUN;
                    s_d.cnt  = '0;
                    s_d.cand = cand_i;
                    s_d.bvld = 1'b0;
                    s_d.bidx = '0;
                    s_d.bid  = '0;
                end
            end
            SCAN_RUN: begin
                take = s_q.cand[s_q.cnt] && live_i[s_q.cnt]
                       && (!s_q.bvld || (cur_id < s_q.bid));
                if (take) begin
                    s_d.bvld = 1'b1;
                    s_d.bidx = s_q.cnt;
                    s_d.bid  = cur_id;
                end
                if (last) begin
                    s_d.st = SCAN_IDLE;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            default: s_d.st = SCAN_IDLE;
        endcase
        busy_o  = (s_q.st == SCAN_RUN);
        fin_o   = busy_o && last;
        found_o = take || s_q.bvld;
        idx_o   = take ? s_q.cnt : s_q.bidx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/txq_slot.sv
// Request bookkeeping for one transmit buffer.
module txq_slot (
    input  logic clk,
    input  logic rst_n,
    input  logic add_wr_i,
    input  logic cnl_wr_i,
    input  logic scan_busy_i,
    input  logic act_i,
    input  logic fr_ok_i,
    input  logic fr_fail_i,
    input  logic darm_i,
    output logic pend_o,
    output logic add_o,
    output logic creq_o,
    output logic done_o,
    output logic ok_o,
    output logic acc_o,
    output logic drop_o
);
    typedef struct packed {
        logic pend;
        logic add;
        logic creq;
        logic done;
        logic ok;
    } slot_t;

    slot_t b_d, b_q;
    logic  acc;
    logic  canc_now;

    always_comb begin
        b_d      = b_q;
        acc      = !scan_busy_i && (b_q.add || add_wr_i) && !b_q.pend;
        canc_now = b_q.creq && !act_i;

        // add path: held during a scan, applied otherwise
        if (scan_busy_i) begin
            b_d.add = b_q.add || (add_wr_i && !b_q.pend);
        end else begin
            b_d.add = 1'b0;
            if (acc) begin
                b_d.pend = 1'b1;
                b_d.done = 1'b0;
                b_d.ok   = 1'b0;
            end
        end

        if (cnl_wr_i) b_d.creq = 1'b1;

        // cancel of a buffer that is not on the bus
        if (canc_now) begin
            if (b_q.pend || b_q.add || acc) begin
                b_d.pend = 1'b0;
                b_d.add  = 1'b0;
                b_d.done = 1'b1;
            end else if (!b_d.add) begin
                b_d.creq = 1'b0;
            end
        end

        // frame outcome for the buffer on the bus
        if (act_i) begin
            if (fr_ok_i) begin
                b_d.pend = 1'b0;
                b_d.ok   = 1'b1;
                if (b_q.creq) b_d.done = 1'b1;
            end else if (fr_fail_i) begin
                if (b_q.creq || darm_i) begin
                    b_d.pend = 1'b0;
                    b_d.done = 1'b1;
                end
            end
        end

        pend_o = b_q.pend;
        add_o  = b_q.add;
        creq_o = b_q.creq;
        done_o = b_q.done;
        ok_o   = b_q.ok;
        acc_o  = acc;
        drop_o = canc_now && b_q.pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end
endmodule

// File: rtl/txq_sched.sv
module txq_sched
    import txq_pkg::*;
#(
    parameter int NBUF = 3,
    parameter int IDW  = 11,
    localparam int IW  = (NBUF > 1) ? $clog2(NBUF) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                add_we,
    input  logic [REG_W-1:0]    add_wdata,
    input  logic                cnl_we,
    input  logic [REG_W-1:0]    cnl_wdata,
    input  logic                darm_i,
    input  logic [NBUF*IDW-1:0] msg_id_i,
    output logic [REG_W-1:0]    pend_o,
    output logic [REG_W-1:0]    addreq_o,
    output logic [REG_W-1:0]    cnlreq_o,
    output logic [REG_W-1:0]    cnldone_o,
    output logic [REG_W-1:0]    txok_o,
    output logic                sel_vld_o,
    output logic [IW-1:0]       sel_idx_o,
    input  logic                eng_start_i,
    input  logic                eng_ok_i,
    input  logic                eng_arb_i,
    input  logic                eng_err_i
);
    localparam int PADW = REG_W - NBUF;

    typedef struct packed {
        logic          sel_vld;
        logic [IW-1:0] sel_idx;
        logic          act;
        logic [IW-1:0] act_idx;
        logic          rescan;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [NBUF-1:0] add_m, cnl_m;
    logic [NBUF-1:0] pend_v, add_v, creq_v, done_v, ok_v, acc_v, drop_v;
    logic            busy_w, fin_w, found_w;
    logic [IW-1:0]   idx_w;
    logic            start_w, go_w, fr_end_w, fr_ok_w, fr_fail_w;
    logic            act_w;
    logic [IW-1:0]   act_idx_w;
    logic            unused_wdata;

    assign add_m        = add_we ? add_wdata[NBUF-1:0] : '0;
    assign cnl_m        = cnl_we ? cnl_wdata[NBUF-1:0] : '0;
    assign unused_wdata = ^{add_wdata[REG_W-1:NBUF], cnl_wdata[REG_W-1:NBUF]};
    assign fr_ok_w      = eng_ok_i;
    assign fr_fail_w    = (eng_arb_i || eng_err_i) && !eng_ok_i;
    assign act_w        = c_q.act;
    assign act_idx_w    = c_q.act_idx;

    for (genvar g = 0; g < NBUF; g++) begin : g_slot
        txq_slot u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .add_wr_i    (add_m[g]),
            .cnl_wr_i    (cnl_m[g]),
            .scan_busy_i (busy_w),
            .act_i       (c_q.act && (c_q.act_idx == IW'(g))),
            .fr_ok_i     (fr_ok_w),
            .fr_fail_i   (fr_fail_w),
            .darm_i      (darm_i),
            .pend_o      (pend_v[g]),
            .add_o       (add_v[g]),
            .creq_o      (creq_v[g]),
            .done_o      (done_v[g]),
            .ok_o        (ok_v[g]),
            .acc_o       (acc_v[g]),
            .drop_o      (drop_v[g])
        );
    end

    txq_scan #(
        .NBUF (NBUF),
        .IDW  (IDW)
    ) u_scan (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_w),
        .cand_i  (pend_v),
        .live_i  (pend_v),
        .ids_i   (msg_id_i),
        .busy_o  (busy_w),
        .fin_o   (fin_w),
        .found_o (found_w),
        .idx_o   (idx_w)
    );

    always_comb begin
        c_d      = c_q;
        start_w  = !busy_w && c_q.rescan && !c_q.act;
        go_w     = eng_start_i && c_q.sel_vld && !busy_w && !drop_v[c_q.sel_idx];
        fr_end_w = c_q.act && (eng_ok_i || eng_arb_i || eng_err_i);

        if (start_w) c_d.rescan = 1'b0;
        if ((|acc_v) || (|drop_v) || fr_end_w) c_d.rescan = 1'b1;

        // withdraw an offer whose buffer is being cancelled
        if (c_q.sel_vld && drop_v[c_q.sel_idx]) c_d.sel_vld = 1'b0;

        if (go_w) begin
            c_d.sel_vld = 1'b0;
            c_d.act     = 1'b1;
            c_d.act_idx = c_q.sel_idx;
        end

        if (fr_end_w) c_d.act = 1'b0;

        if (fin_w) begin
            c_d.sel_vld = found_w && !drop_v[idx_w];
            c_d.sel_idx = idx_w;
            if (found_w && drop_v[idx_w]) c_d.rescan = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign pend_o    = {{PADW{1'b0}}, pend_v};
    assign addreq_o  = {{PADW{1'b0}}, add_v};
    assign cnlreq_o  = {{PADW{1'b0}}, creq_v};
    assign cnldone_o = {{PADW{1'b0}}, done_v};
    assign txok_o    = {{PADW{1'b0}}, ok_v};
    assign sel_vld_o = c_q.sel_vld && !busy_w && !drop_v[c_q.sel_idx];
    assign sel_idx_o = c_q.sel_idx;
endmodule

// File: rtl/txq_sched_chk.sv
module txq_sched_chk
    import txq_pkg::*;
#(
    parameter int NBUF = 3,
    parameter int IW   = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             add_we,
    input logic             darm_i,
    input logic             eng_ok_i,
    input logic             eng_arb_i,
    input logic             eng_err_i,
    input logic [REG_W-1:0] pend_o,
    input logic [REG_W-1:0] addreq_o,
    input logic [REG_W-1:0] cnlreq_o,
    input logic [REG_W-1:0] cnldone_o,
    input logic [REG_W-1:0] txok_o,
    input logic             sel_vld_o,
    input logic [IW-1:0]    sel_idx_o,
    input logic             act_w,
    input logic [IW-1:0]    act_idx_w,
    input logic             busy_w
);
    // R1
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o | addreq_o | cnlreq_o | cnldone_o | txok_o) >> NBUF == '0);

    // R2
    pend_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pend_o & ~$past(pend_o))) |-> ($past(add_we) || (|$past(addreq_o))));

    // R3
    held_add_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|addreq_o) |-> $past(busy_w));

    // R6
    creq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|($past(cnlreq_o) & ~cnlreq_o & pend_o)));

    // R8
    txok_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(txok_o & ~$past(txok_o))) |-> $past(act_w && eng_ok_i));

    // R10
    darm_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_w && darm_i && !eng_ok_i && (eng_arb_i || eng_err_i))
        |=> (!pend_o[$past(act_idx_w)] && cnldone_o[$past(act_idx_w)]));

    // R12
    offer_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_vld_o |-> pend_o[sel_idx_o]);
endmodule

bind txq_sched txq_sched_chk #(
    .NBUF (NBUF),
    .IW   (IW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .add_we    (add_we),
    .darm_i    (darm_i),
    .eng_ok_i  (eng_ok_i),
    .eng_arb_i (eng_arb_i),
    .eng_err_i (eng_err_i),
    .pend_o    (pend_o),
    .addreq_o  (addreq_o),
    .cnlreq_o  (cnlreq_o),
    .cnldone_o (cnldone_o),
    .txok_o    (txok_o),
    .sel_vld_o (sel_vld_o),
    .sel_idx_o (sel_idx_o),
    .act_w     (act_w),
    .act_idx_w (act_idx_w),
    .busy_w    (busy_w)
);

// File: tb/txq_sched_bench.sv
`timescale 1ns/1ps
module txq_sched_bench;
    localparam int NBUF = 3;
    localparam int IDW  = 3;
    localparam int IW   = 2;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                add_we = 1'b0, cnl_we = 1'b0, darm = 1'b0;
    logic [31:0]         add_wdata = '0, cnl_wdata = '0;
    logic [NBUF*IDW-1:0] msg_id = '0;
    logic [31:0]         pend, addreq, cnlreq, cnldone, txok;
    logic                sel_vld;
    logic [IW-1:0]       sel_idx;
    logic                e_start = 1'b0, e_ok = 1'b0, e_arb = 1'b0, e_err = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    txq_sched #(.NBUF(NBUF), .IDW(IDW)) u_txq_sched (
        .clk(clk), .rst_n(rst_n),
        .add_we(add_we), .add_wdata(add_wdata),
        .cnl_we(cnl_we), .cnl_wdata(cnl_wdata),
        .darm_i(darm), .msg_id_i(msg_id),
        .pend_o(pend), .addreq_o(addreq), .cnlreq_o(cnlreq),
        .cnldone_o(cnldone), .txok_o(txok),
        .sel_vld_o(sel_vld), .sel_idx_o(sel_idx),
        .eng_start_i(e_start), .eng_ok_i(e_ok), .eng_arb_i(e_arb), .eng_err_i(e_err)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic skip(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_add(input logic [31:0] m);
        @(negedge clk); add_we = 1'b1; add_wdata = m;
        @(negedge clk); add_we = 1'b0; add_wdata = '0;
    endtask

    task automatic wr_cnl(input logic [31:0] m);
        @(negedge clk); cnl_we = 1'b1; cnl_wdata = m;
        @(negedge clk); cnl_we = 1'b0; cnl_wdata = '0;
    endtask

    // 0 start, 1 success, 2 lost arbitration, 3 error
    task automatic eng(input int k);
        @(negedge clk);
        e_start = (k == 0); e_ok = (k == 1); e_arb = (k == 2); e_err = (k == 3);
        @(negedge clk);
        e_start = 1'b0; e_ok = 1'b0; e_arb = 1'b0; e_err = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; darm = 1'b0;
        skip(3);
        rst_n = 1'b1;
        skip(1);
    endtask

    function automatic int exp_sel(input logic [NBUF*IDW-1:0] ids, input int m);
        int best = -1;
        int bid  = 0;
        for (int i = 0; i < NBUF; i++) begin
            int id = int'(ids[i*IDW +: IDW]);
            if (m[i] && (best < 0 || id < bid)) begin
                best = i;
                bid  = id;
            end
        end
        return best;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] exp_done;
        skip(2);
        // R1 reset state
        chk("R1", "pend in reset", pend, 0);
        chk("R1", "done in reset", cnldone, 0);
        rst_n = 1'b1;
        skip(1);
        chk("R1", "sel after reset", {31'd0, sel_vld}, 0);
        chk("R1", "status after reset", pend | addreq | cnlreq | cnldone | txok, 0);

        // R4 R2 R6 R11 sweep over all identifier triples and masks
        exp_done = '0;
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                for (int c = 0; c < 8; c++) begin
                    for (int m = 1; m < 8; m++) begin
                        msg_id = {3'(c), 3'(b), 3'(a)};
                        wr_add(32'(m));
                        skip(3);
                        chk("R4", "offer hidden while scanning", {31'd0, sel_vld}, 0);
                        skip(1);
                        chk("R4", "offer valid", {31'd0, sel_vld}, 1);
                        chk("R4", "offer index", {30'd0, sel_idx}, 32'(exp_sel(msg_id, m)));
                        chk("R2", "pending mask", pend, 32'(m));
                        chk("R3", "no held add", addreq, 0);
                        wr_cnl(32'h7);
                        skip(1);
                        exp_done = exp_done | 32'(m);
                        chk("R6", "pending after cancel", pend, 0);
                        chk("R6", "cancel finished", cnldone, exp_done);
                        chk("R6", "offer withdrawn", {31'd0, sel_vld}, 0);
                        skip(1);
                        chk("R6", "cancel request cleared", cnlreq, 0);
                        skip(6);
                    end
                end
            end
        end

        // R3 R5 add during a scan
        do_reset();
        msg_id = {3'd7, 3'd2, 3'd5};
        wr_add(32'h1);
        wr_add(32'h2);
        chk("R3", "add held during scan", addreq, 32'h2);
        chk("R3", "pending during scan", pend, 32'h1);
        skip(2);
        chk("R5", "late add not a candidate", {30'd0, sel_idx}, 0);
        chk("R3", "add still held at scan end", addreq, 32'h2);
        skip(1);
        chk("R3", "held add applied", pend, 32'h3);
        chk("R3", "held add cleared", addreq, 0);
        skip(4);
        chk("R4", "rescan picks lower id", {31'd0, sel_vld, 1'b0} | {30'd0, sel_idx}, 32'h3);

        // R2 add to a pending buffer is ignored
        wr_add(32'h2);
        chk("R2", "pending unchanged", pend, 32'h3);
        for (int i = 0; i < 4; i++) begin
            skip(1);
            chk("R2", "offer kept, no rescan", {31'd0, sel_vld}, 1);
        end

        // R12 R9 R8 engine outcomes
        eng(0);
        chk("R12", "offer taken", {31'd0, sel_vld}, 0);
        eng(3);
        chk("R9", "error keeps pending", pend, 32'h3);
        chk("R9", "no cancel finished", cnldone, 0);
        skip(4);
        chk("R9", "retry offered", {31'd0, sel_vld, 1'b0} | {30'd0, sel_idx}, 32'h3);
        eng(0);
        eng(2);
        chk("R9", "lost arbitration keeps pending", pend, 32'h3);
        skip(4);
        chk("R12", "frame end rescans", {31'd0, sel_vld, 1'b0} | {30'd0, sel_idx}, 32'h3);
        eng(0);
        eng(1);
        chk("R8", "success clears pending", pend, 32'h1);
        chk("R8", "transmission occurred", txok, 32'h2);
        chk("R8", "done untouched", cnldone, 0);
        skip(4);
        chk("R12", "next buffer offered", {31'd0, sel_vld, 1'b0} | {30'd0, sel_idx}, 32'h2);

        // R7 deferred cancel
        do_reset();
        msg_id = {3'd7, 3'd2, 3'd5};
        wr_add(32'h1);
        skip(4);
        eng(0);
        wr_cnl(32'h1);
        chk("R7", "cancel request latched", cnlreq, 32'h1);
        skip(2);
        chk("R7", "pending held on bus", pend, 32'h1);
        chk("R7", "not finished yet", cnldone, 0);
        eng(2);
        chk("R7", "cleared at frame end", pend, 0);
        chk("R7", "finished on lost arbitration", cnldone, 32'h1);
        skip(1);
        chk("R7", "cancel request cleared", cnlreq, 0);
        skip(6);
        wr_add(32'h4);
        skip(4);
        chk("R4", "single buffer offered", {30'd0, sel_idx}, 32'h2);
        eng(0);
        wr_cnl(32'h4);
        eng(1);
        chk("R7", "success with cancel", txok, 32'h4);
        chk("R7", "finished with success", cnldone, 32'h5);
        skip(6);

        // R11 new add clears completion flags
        wr_add(32'h4);
        chk("R11", "done bit cleared", cnldone, 32'h1);
        chk("R11", "ok bit cleared", txok, 0);
        skip(4);

        // R10 automatic retransmission disabled
        darm = 1'b1;
        eng(0);
        eng(3);
        chk("R10", "failed frame dropped", pend, 0);
        chk("R10", "failed frame finished", cnldone, 32'h5);
        skip(6);
        wr_add(32'h4);
        skip(4);
        eng(0);
        eng(1);
        chk("R10", "success still sets ok", txok, 32'h4);
        chk("R10", "success leaves done clear", cnldone, 32'h1);
        darm = 1'b0;

        // R6 cancel of an add held during a scan
        do_reset();
        wr_add(32'h1);
        wr_add(32'h2);
        wr_cnl(32'h2);
        chk("R6", "held add before cancel", addreq, 32'h2);
        skip(1);
        chk("R6", "held add cancelled", addreq, 0);
        chk("R6", "cancelled add not pending", pend, 32'h1);
        chk("R6", "cancelled add finished", cnldone, 32'h2);
        skip(1);
        chk("R6", "cancel request cleared", cnlreq, 0);

        // R1 bits above the buffers
        do_reset();
        wr_add(32'hFFFF_FFF8);
        chk("R1", "upper add bits ignored", pend | addreq, 0);
        wr_cnl(32'hFFFF_FFF8);
        chk("R1", "upper cancel bits ignored", cnlreq, 0);
        skip(6);
        chk("R1", "no offer", {31'd0, sel_vld}, 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule